// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Command and Data Pipeline

This block models, cycle by cycle, the command and data pipeline of a common-I/O synchronous SRAM that moves every access as a pair of double-data-rate beats. It runs on a single clock at twice the K rate. An internal phase bit, set by reset, marks each rising edge as either a K edge or a K# edge. The first edge after reset is always a K edge. Only K edges sample a command: an active-low load strobe, a read/write select and a word-pair address. The lowest bit of the storage index is never an input. The pipeline generates it: 0 for the first beat of a burst and 1 for the second.

Writes are late. Both beats of write data, each with its own active-low per-lane mask, come in after the command edge and are stored in a small behavioural array. Reads present two beats of data starting five half-cycles after the command edge. A valid flag and a data-driver enable are high during both beats. The data-input termination enable drops half a cycle before the read beats and comes back half a cycle after them, but only while the termination input is high.

Top module: `sram_b2_frontend`

## Requirements
- R1: A command is accepted only at a K edge with `loadN` low; `readNotWrite` high selects read and low selects write. With `loadN` high, or at a K# edge, nothing is stored and no read output is produced.
- R2: For a read accepted at K edge e (half-cycle edges counted from e), beat 0 is registered at edge e+5 (a K# edge) and beat 1 at edge e+6. `rdValid` is high after each of these two edges.
- R3: Beat 0 of a burst uses word index {addr, 0} and beat 1 uses {addr, 1}.
- R4: For a write accepted at edge e, `wrData`/`wrMaskN` are captured at edge e+2 (K) as beat 0 and at edge e+3 (K#) as beat 1.
- R5: A word is split into 9-bit lanes, lane i being bits [9i+8:9i]. The bit `wrMaskN[i]` guards lane i in the beat it is sampled with: 0 writes the lane, 1 leaves it unchanged. A mask of all ones aborts that beat.
- R6: A new command may be accepted on every K edge. Back-to-back reads keep `rdValid` high without a gap.
- R7: `drvEn` is high exactly when `rdValid` is high. A deselect that follows a read does not shorten it. While `rdValid` is low, `rdData` is zero.
- R8: With `odtEn` high, `termOn` is low after edges e+4 through e+7 of every read and high otherwise. With `odtEn` low, `termOn` is low.
- R9: A read returns the most recently written value, including a beat written at the edge just before the read beat is registered.
- R10: Synchronous reset clears all pending commands and forces `rdValid`, `drvEn` and `rdData` to zero. It leaves `termOn` equal to `odtEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the K rate; edges alternate K and K# |
| rst | input | 1 | Synchronous active-high reset |
| loadN | input | 1 | Active-low command load strobe, sampled on K edges |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word-pair address (low index bit is internal) |
| wrData | input | LANES*9 | Write beat data |
| wrMaskN | input | LANES | Active-low per-lane write mask, one bit per 9-bit lane |
| odtEn | input | 1 | Input termination enable |
| rdData | output | LANES*9 | Read beat data, zero when not valid |
| rdValid | output | 1 | Read beat valid |
| drvEn | output | 1 | Data-driver enable |
| termOn | output | 1 | Data-input termination active |

## Verification
The assertions rely on three things about the stimulus. The first rising edge after reset is a K edge, and the phase then alternates with no break. Data and masks are valid at the edge where a beat is captured. `odtEn` is only relevant in combination with the internal termination window. The bench meets these conditions as follows. It changes every input on the falling clock edge. It releases reset so that the next edge is a K edge. It keeps `loadN` high before K# edges, except in one directed case that checks a K#-edge load is ignored. It drives write beats only in the two half-cycles that follow a write command. It holds `odtEn` constant across every burst it checks.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

  localparam int LANE_W = 9;

  // per-edge work orders issued by control to the datapath
  typedef struct packed {
    logic wrLo;  // store beat 0 (K edge)
    logic wrHi;  // store beat 1 (K# edge)
    logic rdLo;  // present beat 0 (K# edge)
    logic rdHi;  // present beat 1 (K edge)
  } beatStrobes_t;

endpackage

// File: rtl/sram_b2_ctrl.sv
module sram_b2_ctrl
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadN,
  input  logic              readNotWrite,
  input  logic [ADDR_W-1:0] addr,
  output beatStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              drvEn,
  output logic              termWanted
);

  // half-cycle taps, counted in edges after the command edge minus one
  localparam int WR_LO_TAP  = 1;
  localparam int WR_HI_TAP  = 2;
  localparam int TERM_FIRST = 3;
  localparam int RD_LO_TAP  = 4;
  localparam int RD_HI_TAP  = 5;
  localparam int TERM_LAST  = 6;
  localparam int PIPE_D     = TERM_LAST + 1;

  logic              kNow;
  logic              pipeVld  [PIPE_D];
  logic              pipeRd   [PIPE_D];
  logic [ADDR_W-1:0] pipeAddr [PIPE_D];
  logic              readInWindow;

  always_ff @(posedge clk) begin
    if (rst) begin
      kNow <= 1'b1;
      for (int i = 0; i < PIPE_D; i++) begin
        pipeVld[i]  <= 1'b0;
        pipeRd[i]   <= 1'b0;
        pipeAddr[i] <= '0;
      end
    end else begin
      kNow        <= ~kNow;
      pipeVld[0]  <= kNow & ~loadN;
      pipeRd[0]   <= readNotWrite;
      pipeAddr[0] <= addr;
      for (int i = 1; i < PIPE_D; i++) begin
        pipeVld[i]  <= pipeVld[i-1];
        pipeRd[i]   <= pipeRd[i-1];
        pipeAddr[i] <= pipeAddr[i-1];
      end
    end
  end

  always_comb begin
    strobes.wrLo = pipeVld[WR_LO_TAP] & ~pipeRd[WR_LO_TAP];
    strobes.wrHi = pipeVld[WR_HI_TAP] & ~pipeRd[WR_HI_TAP];
    strobes.rdLo = pipeVld[RD_LO_TAP] &  pipeRd[RD_LO_TAP];
    strobes.rdHi = pipeVld[RD_HI_TAP] &  pipeRd[RD_HI_TAP];
    wrAddr = strobes.wrLo ? pipeAddr[WR_LO_TAP] : pipeAddr[WR_HI_TAP];
    rdAddr = strobes.rdLo ? pipeAddr[RD_LO_TAP] : pipeAddr[RD_HI_TAP];
  end

  always_comb begin
    readInWindow = 1'b0;
    for (int i = TERM_FIRST; i <= TERM_LAST; i++)
      readInWindow = readInWindow | (pipeVld[i] & pipeRd[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drvEn      <= 1'b0;
      termWanted <= 1'b1;
    end else begin
      drvEn      <= strobes.rdLo | strobes.rdHi;
      termWanted <= ~readInWindow;
    end
  end

  // a driven read always spans at least two beats
  assert_beat_pair_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(drvEn) |=> drvEn);

endmodule

// File: rtl/sram_b2_datapath.sv
module sram_b2_datapath
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  beatStrobes_t             strobes,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic [LANES*LANE_W-1:0]  wrData,
  input  logic [LANES-1:0]         wrMaskN,
  output logic [LANES*LANE_W-1:0]  rdData,
  output logic                     rdValid
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int IDX_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << IDX_W;

  logic [WORD_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdIdx;
  logic              wrAny;
  logic              rdAny;

  always_comb begin
    wrIdx = {wrAddr, strobes.wrHi};
    rdIdx = {rdAddr, strobes.rdHi};
    wrAny = strobes.wrLo | strobes.wrHi;
    rdAny = strobes.rdLo | strobes.rdHi;
  end

  always_ff @(posedge clk) begin
    if (wrAny) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wrMaskN[l])
          store[wrIdx][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= rdAny ? store[rdIdx] : '0;
      rdValid <= rdAny;
    end
  end

  assert_write_pair_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.wrLo |=> strobes.wrHi);
  assert_read_pair_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.rdLo |=> strobes.rdHi);
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.wrLo, strobes.wrHi}) && $onehot0({strobes.rdLo, strobes.rdHi}));

endmodule

// File: rtl/sram_b2_frontend.sv
module sram_b2_frontend
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadN,
  input  logic                     readNotWrite,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wrData,
  input  logic [LANES-1:0]         wrMaskN,
  input  logic                     odtEn,
  output logic [LANES*LANE_W-1:0]  rdData,
  output logic                     rdValid,
  output logic                     drvEn,
  output logic                     termOn
);

  beatStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic              termWanted;

  sram_b2_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .loadN        (loadN),
    .readNotWrite (readNotWrite),
    .addr         (addr),
    .strobes      (strobes),
    .wrAddr       (wrAddr),
    .rdAddr       (rdAddr),
    .drvEn        (drvEn),
    .termWanted   (termWanted)
  );

  sram_b2_datapath #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrData  (wrData),
    .wrMaskN (wrMaskN),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  assign termOn = odtEn & termWanted;

  assert_drive_window_R7: assert property (@(posedge clk) disable iff (rst)
    rdValid == drvEn);
  assert_term_off_R8: assert property (@(posedge clk) disable iff (rst)
    drvEn |-> !termWanted);

endmodule

// File: tb/test_sram_b2_frontend.sv
module test_sram_b2_frontend;

  localparam int ADDR_W = 4;
  localparam int LANES  = 2;
  localparam int WORD_W = 18;
  localparam int NV     = 16;
  localparam int LAST_N = 2 * NV + 10;

  // {loadN, readNotWrite, addr[3:0], d0[17:0], m0[1:0], d1[17:0], m1[1:0]}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd3, 18'h1A2B3, 2'b00, 18'h2C4D5, 2'b00},
    {1'b0, 1'b0, 4'd5, 18'h0F0F0, 2'b00, 18'h30303, 2'b00},
    {1'b0, 1'b1, 4'd3, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b0, 1'b1, 4'd5, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b0, 1'b0, 4'd3, 18'h3FFFF, 2'b10, 18'h00000, 2'b01},
    {1'b0, 1'b1, 4'd3, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b0, 1'b0, 4'd5, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11},
    {1'b0, 1'b1, 4'd5, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b0, 1'b1, 4'd3, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b1, 1'b0, 4'd3, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00},
    {1'b0, 1'b1, 4'd5, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b0, 1'b0, 4'd5, 18'h12345, 2'b00, 18'h2ABCD, 2'b00},
    {1'b0, 1'b1, 4'd3, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b0, 1'b1, 4'd5, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b1, 1'b1, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11},
    {1'b1, 1'b1, 4'd0, 18'h00000, 2'b11, 18'h00000, 2'b11}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              loadN;
  logic              readNotWrite;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wrData;
  logic [LANES-1:0]  wrMaskN;
  logic              odtEn;
  logic [WORD_W-1:0] rdData;
  logic              rdValid;
  logic              drvEn;
  logic              termOn;

  logic [WORD_W-1:0] model [1 << (ADDR_W + 1)];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_b2_frontend #(.ADDR_W(ADDR_W), .LANES(LANES)) i_sram_b2_frontend (
    .clk(clk), .rst(rst), .loadN(loadN), .readNotWrite(readNotWrite), .addr(addr),
    .wrData(wrData), .wrMaskN(wrMaskN), .odtEn(odtEn),
    .rdData(rdData), .rdValid(rdValid), .drvEn(drvEn), .termOn(termOn)
  );

  function automatic logic [45:0] ent(int j);
    if (j < 0 || j >= NV) return {1'b1, 45'b0};
    return VEC[j];
  endfunction

  function automatic bit isRd(logic [45:0] e);
    return !e[45] && e[44];
  endfunction

  function automatic bit isWr(logic [45:0] e);
    return !e[45] && !e[44];
  endfunction

  task automatic applyBeat(logic [45:0] e, bit hi);
    logic [WORD_W-1:0] d;
    logic [1:0] m;
    int idx;
    d = hi ? e[19:2] : e[39:22];
    m = hi ? e[1:0] : e[21:20];
    idx = {e[43:40], hi};
    for (int l = 0; l < LANES; l++)
      if (!m[l]) model[idx][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic check(string req, bit expValid, logic [WORD_W-1:0] expData, bit expTerm);
    vectors++;
    if (rdValid !== expValid || drvEn !== expValid || rdData !== expData || termOn !== expTerm) begin
      miscompares++;
      $display("FAIL %s: valid=%0b drv=%0b data=%h term=%0b, expected valid=%0b drv=%0b data=%h term=%0b",
               req, rdValid, drvEn, rdData, termOn, expValid, expValid, expData, expTerm);
    end
  endtask

  task automatic idleInputs();
    loadN = 1'b1; readNotWrite = 1'b0; addr = '0; wrData = '0; wrMaskN = '1;
  endtask

  task automatic doReset();
    rst = 1'b1; idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    odtEn = 1'b1;
    doReset();
    // R10: reset state
    check("R10 reset state", 1'b0, '0, 1'b1);
    rst = 1'b0;

    // table walk: covers R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n <= LAST_N; n++) begin
      logic [45:0] e;
      logic [45:0] p;
      logic [WORD_W-1:0] expData;
      bit expValid;
      bit expTerm;
      if (n % 2 == 0) begin
        e = ent(n / 2);
        loadN = e[45]; readNotWrite = e[44]; addr = e[43:40];
        p = ent(n / 2 - 1);
        wrData = p[39:22]; wrMaskN = p[21:20];
      end else begin
        loadN = 1'b1;
        p = ent((n - 3) / 2);
        wrData = p[19:2]; wrMaskN = p[1:0];
      end
      @(posedge clk);
      @(negedge clk);
      expValid = 1'b0; expData = '0;
      if (n % 2 == 1 && n >= 5) begin
        p = ent((n - 5) / 2);
        if (isRd(p)) begin expValid = 1'b1; expData = model[{p[43:40], 1'b0}]; end
      end
      if (n % 2 == 0 && n >= 6) begin
        p = ent((n - 6) / 2);
        if (isRd(p)) begin expValid = 1'b1; expData = model[{p[43:40], 1'b1}]; end
      end
      expTerm = 1'b1;
      for (int k = 4; k <= 7; k++)
        if (n - k >= 0 && (n - k) % 2 == 0 && isRd(ent((n - k) / 2))) expTerm = 1'b0;
      check("R1 R2 R3 R4 R5 R6 R7 R8 R9 table", expValid, expData, expTerm);
      if (n % 2 == 0) begin
        p = ent(n / 2 - 1);
        if (isWr(p)) applyBeat(p, 1'b0);
      end else begin
        p = ent((n - 3) / 2);
        if (isWr(p)) applyBeat(p, 1'b1);
      end
    end

    // R8: termination stays off throughout a read when odtEn is low
    doReset(); odtEn = 1'b0; rst = 1'b0;
    for (int n = 0; n <= 8; n++) begin
      idleInputs();
      if (n == 0) begin loadN = 1'b0; readNotWrite = 1'b1; addr = 4'd5; end
      @(posedge clk); @(negedge clk);
      if (n == 5) check("R8 odt off beat0", 1'b1, model[{4'd5, 1'b0}], 1'b0);
      else if (n == 6) check("R8 odt off beat1", 1'b1, model[{4'd5, 1'b1}], 1'b0);
      else check("R8 odt off idle", 1'b0, '0, 1'b0);
    end
    odtEn = 1'b1;

    // R1: a load at a K# edge is ignored
    doReset(); rst = 1'b0;
    for (int n = 0; n <= 9; n++) begin
      idleInputs();
      if (n == 1) begin loadN = 1'b0; readNotWrite = 1'b1; addr = 4'd3; end
      @(posedge clk); @(negedge clk);
      check("R1 K# load ignored", 1'b0, '0, 1'b1);
    end

    // R10: reset in the middle of a pending read clears it
    doReset(); rst = 1'b0;
    for (int n = 0; n <= 9; n++) begin
      idleInputs();
      if (n == 0) begin loadN = 1'b0; readNotWrite = 1'b1; addr = 4'd3; end
      rst = (n == 3);
      @(posedge clk); @(negedge clk);
      if (n < 3) check("R10 pre-reset idle", 1'b0, '0, 1'b1);
      else check("R10 burst flushed by reset", 1'b0, '0, 1'b1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule